// File: doc/BRIEF.md
# Four-Node Directory Home Controller

This block is the home side of a directory coherence scheme for a four-node distributed shared memory. Each memory line owned by this home has a directory entry. The entry holds the line's state, a sharer bit vector with one bit per node, the owning node's number, and the line's memory data. Nodes send read and write requests as point-to-point messages on a request channel. They answer the home's invalidations and fetches on a separate response channel. The home itself talks on three output channels: a reply channel for data to the requester, a forward channel for invalidations and fetches, and a retry channel. Every channel carries at most one message per cycle.

A line's home is chosen by the low-order bits of its line address. Only lines whose low bits equal the `HOME_ID` parameter are handled here. The rest of the address selects the directory entry.

The controller runs one transaction at a time, using three states:
- `FSM_IDLE`: serves requests that can be answered at once, with a single-cycle reply.
- `FSM_INVAL`: sends one invalidation per cycle, in ascending node order, and counts acknowledgements down.
- `FSM_OWNER`: waits for the current owner to return the line.

The transitions are:
- IDLE to INVAL: a write to a line that has sharers other than the writer.
- IDLE to OWNER: any request to a line held Modified by another node.
- INVAL to IDLE: the grant, issued once no invalidation is left to send and the counter has reached zero.
- OWNER to IDLE: the owner's data arrives and is answered.

While the controller is in INVAL or OWNER, every request for this home is answered with a retry.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is Uncached with an empty sharer set and all-zero data, and reply_valid, fwd_valid and nack_valid are low.
- R2: A request whose line address low bits differ from HOME_ID produces no message on any output and leaves every directory entry unchanged.
- R3: In the idle state, a read (req_kind 0) of an Uncached or Shared line is answered in the next cycle. The reply has reply_kind 0 (shared data), the requester as destination, the request's line, and the memory data. The reader is added to the sharer set and the line becomes Shared.
- R4: In the idle state, a write (req_kind 1) to an Uncached line, or to a Shared line whose only sharer is the writer, is granted in the next cycle. The grant has reply_kind 1 (exclusive) and the memory data, and no invalidation is sent.
- R5: A write to a Shared line with other sharers sends one invalidation (fwd_kind 0) per cycle to each other sharer, in ascending node number. The first invalidation appears two cycles after the request.
- R6: The acknowledgement counter is loaded with the number of sharers other than the writer. An acknowledgement is rsp_kind 0. The exclusive grant, carrying the memory data, is issued in the cycle after the acknowledgement that brings the counter to zero, and not before. The line then becomes Modified with the writer as sole owner, and all former sharers are dropped.
- R7: A read of a line Modified by another node sends a fetch (fwd_kind 1) to the owner in the next cycle. When the owner returns data (rsp_kind 1), memory is updated and that data is replied as shared (reply_kind 0) in the following cycle. The owner and the reader are then both sharers.
- R8: A write to a line Modified by another node sends a fetch-and-invalidate (fwd_kind 2) to the owner. On the owner's data, the writer is granted exclusive (reply_kind 1) with that data and becomes the sole owner. The previous owner keeps no copy.
- R9: While a transaction is open, every request for this home is answered in the next cycle on the retry channel with the requester and line, and it changes no directory entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_kind | input | 1 | 0 read, 1 write |
| req_src | input | 2 | Requesting node |
| req_line | input | LINE_W | Line address |
| rsp_valid | input | 1 | Response message present |
| rsp_kind | input | 1 | 0 invalidation acknowledgement, 1 owner data |
| rsp_src | input | 2 | Responding node |
| rsp_data | input | 8 | Data returned by an owner |
| reply_valid | output | 1 | Data reply present |
| reply_kind | output | 1 | 0 shared data, 1 exclusive grant |
| reply_dst | output | 2 | Destination node |
| reply_line | output | LINE_W | Line address |
| reply_data | output | 8 | Line data |
| fwd_valid | output | 1 | Forwarded message present |
| fwd_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch and invalidate |
| fwd_dst | output | 2 | Target node |
| fwd_line | output | LINE_W | Line address |
| nack_valid | output | 1 | Retry message present |
| nack_dst | output | 2 | Node told to retry |
| nack_line | output | LINE_W | Line address of the refused request |

## Verification
The bench builds the block with HOME_ID set to 1 and LINE_W set to 5, giving eight directory entries. With this setting, a foreign address that shares an entry index with a home line can be issued, which shows that filtered requests really leave the entry alone. A non-zero home number also catches a decoder that only accepts node 0. Two- and three-sharer invalidation rounds, ownership moving between three different nodes, and retries arriving during both wait states are all reachable within a single line's history.

// File: rtl/coh_pkg.sv
package coh_pkg;
    parameter int NODES  = 4;
    parameter int NID_W  = $clog2(NODES);
    parameter int DATA_W = 8;

    typedef enum logic [1:0] {LN_UNC, LN_SHR, LN_MOD} line_st_e;
    typedef enum logic [1:0] {FSM_IDLE, FSM_INVAL, FSM_OWNER} fsm_e;

    typedef struct packed {
        line_st_e         st;
        logic [NODES-1:0] shr;
        logic [NID_W-1:0] own;
    } dir_ent_t;

    localparam logic       RQ_RD = 1'b0;
    localparam logic       RQ_WR = 1'b1;
    localparam logic       RS_ACK = 1'b0;
    localparam logic       RS_DATA = 1'b1;
    localparam logic       REP_SHR = 1'b0;
    localparam logic       REP_EXCL = 1'b1;
    localparam logic [1:0] FWD_INV = 2'd0;
    localparam logic [1:0] FWD_FETCH = 2'd1;
    localparam logic [1:0] FWD_FETCH_INV = 2'd2;

    function automatic logic [NODES-1:0] node_bit(input logic [NID_W-1:0] n);
        return NODES'(1) << n;
    endfunction
endpackage

// File: rtl/coh_popcnt.sv
module coh_popcnt import coh_pkg::*; #(
    parameter int CNT_W = $clog2(NODES + 1)
) (
    input  logic [NODES-1:0] mask,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < NODES; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end
endmodule

// File: rtl/coh_lowpick.sv
module coh_lowpick import coh_pkg::*; (
    input  logic [NODES-1:0] mask,
    output logic [NID_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (mask[i]) idx = NID_W'(i);
        end
    end
endmodule

// File: rtl/coh_dir_store.sv
module coh_dir_store import coh_pkg::*; #(
    parameter int IDX_W = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output dir_ent_t          rd_ent,
    output logic [DATA_W-1:0] rd_dat,
    input  logic              ent_we,
    input  logic              dat_we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  dir_ent_t          wr_ent,
    input  logic [DATA_W-1:0] wr_dat
);
    dir_ent_t          ent_q [DEPTH];
    logic [DATA_W-1:0] dat_q [DEPTH];

    assign rd_ent = ent_q[rd_idx];
    assign rd_dat = dat_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '{st: LN_UNC, shr: '0, own: '0};
                dat_q[i] <= '0;
            end
        end else begin
            if (ent_we) ent_q[wr_idx] <= wr_ent;
            if (dat_we) dat_q[wr_idx] <= wr_dat;
        end
    end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir import coh_pkg::*; #(
    parameter int LINE_W  = 6,
    parameter int HOME_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [NID_W-1:0]  req_src,
    input  logic [LINE_W-1:0] req_line,
    input  logic              rsp_valid,
    input  logic              rsp_kind,
    input  logic [NID_W-1:0]  rsp_src,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              reply_valid,
    output logic              reply_kind,
    output logic [NID_W-1:0]  reply_dst,
    output logic [LINE_W-1:0] reply_line,
    output logic [DATA_W-1:0] reply_data,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [NID_W-1:0]  fwd_dst,
    output logic [LINE_W-1:0] fwd_line,
    output logic              nack_valid,
    output logic [NID_W-1:0]  nack_dst,
    output logic [LINE_W-1:0] nack_line
);
    localparam int IDX_W = LINE_W - NID_W;
    localparam int CNT_W = $clog2(NODES + 1);

    fsm_e              fsm_q, fsm_d;
    logic [NID_W-1:0]  src_q, src_d, own_q, own_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              wr_q, wr_d;
    logic [NODES-1:0]  pend_q, pend_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    logic              rep_v_d, rep_k_d, fwd_v_d, nack_v_d;
    logic [NID_W-1:0]  rep_dst_d, fwd_dst_d;
    logic [LINE_W-1:0] rep_line_d, fwd_line_d;
    logic [DATA_W-1:0] rep_dat_d;
    logic [1:0]        fwd_k_d;

    logic              req_home, ack_in, wb_in;
    logic [IDX_W-1:0]  req_idx, txn_idx, rd_idx, wr_idx;
    dir_ent_t          rd_ent, wr_ent;
    logic [DATA_W-1:0] rd_dat, wr_dat;
    logic              ent_we, dat_we;
    logic [NODES-1:0]  others;
    logic [CNT_W-1:0]  oth_cnt;
    logic [NID_W-1:0]  pick_idx;

    assign req_home = req_valid && (req_line[NID_W-1:0] == NID_W'(HOME_ID));
    assign req_idx  = req_line[LINE_W-1:NID_W];
    assign txn_idx  = line_q[LINE_W-1:NID_W];
    assign rd_idx   = (fsm_q == FSM_IDLE) ? req_idx : txn_idx;
    assign others   = rd_ent.shr & ~node_bit(req_src);
    assign ack_in   = rsp_valid && (rsp_kind == RS_ACK);
    assign wb_in    = rsp_valid && (rsp_kind == RS_DATA) && (rsp_src == own_q);

    coh_dir_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_ent(rd_ent), .rd_dat(rd_dat),
        .ent_we(ent_we), .dat_we(dat_we), .wr_idx(wr_idx), .wr_ent(wr_ent), .wr_dat(wr_dat)
    );
    coh_popcnt #(.CNT_W(CNT_W)) u_cnt (.mask(others), .count(oth_cnt));
    coh_lowpick u_pick (.mask(pend_q), .idx(pick_idx));

    always_comb begin
        fsm_d = fsm_q;  src_d = src_q;  own_d = own_q;  line_d = line_q;
        wr_d = wr_q;    pend_d = pend_q; cnt_d = cnt_q;
        rep_v_d = 1'b0; rep_k_d = REP_SHR; rep_dst_d = src_q; rep_line_d = line_q;
        rep_dat_d = rd_dat;
        fwd_v_d = 1'b0; fwd_k_d = FWD_INV; fwd_dst_d = '0; fwd_line_d = line_q;
        nack_v_d = 1'b0;
        ent_we = 1'b0; dat_we = 1'b0; wr_idx = txn_idx; wr_ent = rd_ent; wr_dat = rsp_data;
        unique case (fsm_q)
            FSM_IDLE: begin
                if (req_home) begin
                    src_d = req_src; line_d = req_line; wr_d = req_kind;
                    rep_dst_d = req_src; rep_line_d = req_line; wr_idx = req_idx;
                    if (rd_ent.st == LN_MOD && rd_ent.own != req_src) begin
                        fwd_v_d = 1'b1; fwd_dst_d = rd_ent.own; fwd_line_d = req_line;
                        fwd_k_d = (req_kind == RQ_WR) ? FWD_FETCH_INV : FWD_FETCH;
                        own_d = rd_ent.own; fsm_d = FSM_OWNER;
                    end else if (rd_ent.st == LN_MOD) begin
                        rep_v_d = 1'b1; rep_k_d = REP_EXCL;
                    end else if (req_kind == RQ_RD) begin
                        rep_v_d = 1'b1; rep_k_d = REP_SHR; ent_we = 1'b1;
                        wr_ent = '{st: LN_SHR, shr: rd_ent.shr | node_bit(req_src), own: rd_ent.own};
                    end else if (oth_cnt == '0) begin
                        rep_v_d = 1'b1; rep_k_d = REP_EXCL; ent_we = 1'b1;
                        wr_ent = '{st: LN_MOD, shr: node_bit(req_src), own: req_src};
                    end else begin
                        pend_d = others; cnt_d = oth_cnt; fsm_d = FSM_INVAL;
                    end
                end
            end
            FSM_INVAL: begin
                nack_v_d = req_home;
                if (pend_q != '0) begin
                    fwd_v_d = 1'b1; fwd_k_d = FWD_INV; fwd_dst_d = pick_idx;
                    pend_d = pend_q & ~node_bit(pick_idx);
                end
                if (ack_in && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
                if (pend_q == '0 && cnt_d == '0) begin
                    rep_v_d = 1'b1; rep_k_d = REP_EXCL; ent_we = 1'b1;
                    wr_ent = '{st: LN_MOD, shr: node_bit(src_q), own: src_q};
                    fsm_d = FSM_IDLE;
                end
            end
            FSM_OWNER: begin
                nack_v_d = req_home;
                if (wb_in) begin
                    dat_we = 1'b1; ent_we = 1'b1; rep_v_d = 1'b1; rep_dat_d = rsp_data;
                    if (wr_q == RQ_WR) begin
                        rep_k_d = REP_EXCL;
                        wr_ent = '{st: LN_MOD, shr: node_bit(src_q), own: src_q};
                    end else begin
                        rep_k_d = REP_SHR;
                        wr_ent = '{st: LN_SHR, shr: node_bit(own_q) | node_bit(src_q), own: own_q};
                    end
                    fsm_d = FSM_IDLE;
                end
            end
            default: fsm_d = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= FSM_IDLE; src_q <= '0; own_q <= '0; line_q <= '0;
            wr_q <= 1'b0; pend_q <= '0; cnt_q <= '0;
        end else begin
            fsm_q <= fsm_d; src_q <= src_d; own_q <= own_d; line_q <= line_d;
            wr_q <= wr_d; pend_q <= pend_d; cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_valid <= 1'b0; reply_kind <= 1'b0; reply_dst <= '0; reply_line <= '0;
            reply_data <= '0; fwd_valid <= 1'b0; fwd_kind <= '0; fwd_dst <= '0;
            fwd_line <= '0; nack_valid <= 1'b0; nack_dst <= '0; nack_line <= '0;
        end else begin
            reply_valid <= rep_v_d; reply_kind <= rep_k_d; reply_dst <= rep_dst_d;
            reply_line <= rep_line_d; reply_data <= rep_dat_d;
            fwd_valid <= fwd_v_d; fwd_kind <= fwd_k_d; fwd_dst <= fwd_dst_d;
            fwd_line <= fwd_line_d;
            nack_valid <= nack_v_d; nack_dst <= req_src; nack_line <= req_line;
        end
    end

    // R2: nothing leaves for a line of another home
    p_home_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid |-> reply_line[NID_W-1:0] == NID_W'(HOME_ID));
    // R5: forwarded traffic only exists with a transaction open
    p_fwd_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> fsm_q != FSM_IDLE);
    // R6: grant only after every invalidation is out and the count is spent
    p_grant_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && $past(fsm_q) == FSM_INVAL) |->
        ($past(pend_q) == '0 && $past(cnt_q) <= CNT_W'(1)));
    // R7: owner-path reply follows an owner response
    p_owner_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && $past(fsm_q) == FSM_OWNER) |-> $past(rsp_valid));
    // R9: retries are issued only while a transaction was open
    p_nack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nack_valid |-> $past(fsm_q) != FSM_IDLE);
endmodule

// File: tb/tb_coh_home_dir.sv
`timescale 1ns/1ps
module tb_coh_home_dir;
    localparam int LW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_kind = 1'b0, rsp_valid = 1'b0, rsp_kind = 1'b0;
    logic [1:0] req_src = '0, rsp_src = '0;
    logic [LW-1:0] req_line = '0;
    logic [7:0] rsp_data = '0;
    logic reply_valid, reply_kind, fwd_valid, nack_valid;
    logic [1:0] reply_dst, fwd_kind, fwd_dst, nack_dst;
    logic [LW-1:0] reply_line, fwd_line, nack_line;
    logic [7:0] reply_data;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    coh_home_dir #(.LINE_W(LW), .HOME_ID(1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_src(rsp_src), .rsp_data(rsp_data),
        .reply_valid(reply_valid), .reply_kind(reply_kind), .reply_dst(reply_dst),
        .reply_line(reply_line), .reply_data(reply_data), .fwd_valid(fwd_valid),
        .fwd_kind(fwd_kind), .fwd_dst(fwd_dst), .fwd_line(fwd_line),
        .nack_valid(nack_valid), .nack_dst(nack_dst), .nack_line(nack_line)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        req_valid = 1'b0; rsp_valid = 1'b0;
    endtask

    task automatic req(input logic k, input int s, input int l);
        req_valid = 1'b1; req_kind = k; req_src = 2'(s); req_line = LW'(l);
    endtask

    task automatic rsp(input logic k, input int s, input int d);
        rsp_valid = 1'b1; rsp_kind = k; rsp_src = 2'(s); rsp_data = 8'(d);
    endtask

    task automatic expect_reply(input string rq, input int k, input int dst, input int l, input int d);
        chk(rq, "reply_valid", int'(reply_valid), 1);
        chk(rq, "reply_kind", int'(reply_kind), k);
        chk(rq, "reply_dst", int'(reply_dst), dst);
        chk(rq, "reply_line", int'(reply_line), l);
        chk(rq, "reply_data", int'(reply_data), d);
    endtask

    task automatic expect_fwd(input string rq, input int k, input int dst, input int l);
        chk(rq, "fwd_valid", int'(fwd_valid), 1);
        chk(rq, "fwd_kind", int'(fwd_kind), k);
        chk(rq, "fwd_dst", int'(fwd_dst), dst);
        chk(rq, "fwd_line", int'(fwd_line), l);
    endtask

    task automatic expect_quiet(input string rq);
        chk(rq, "reply_valid", int'(reply_valid), 0);
        chk(rq, "fwd_valid", int'(fwd_valid), 0);
        chk(rq, "nack_valid", int'(nack_valid), 0);
    endtask

    task automatic t_reset();
        expect_quiet("R1");
    endtask

    task automatic t_home_filter();
        req(1, 3, 2); step(); expect_quiet("R2");       // foreign line aliasing entry 0
        step(); expect_quiet("R2");
        req(0, 0, 1); step(); expect_reply("R1", 0, 0, 1, 0); // still uncached, zero data
        chk("R2", "fwd_valid", int'(fwd_valid), 0);
    endtask

    task automatic t_read_shared();
        req(0, 2, 1); step(); expect_reply("R3", 0, 2, 1, 0);
        chk("R3", "fwd_valid", int'(fwd_valid), 0);
    endtask

    task automatic t_inval_round();                     // sharers {0,2}, node 3 writes
        req(1, 3, 1); step(); expect_quiet("R5");
        step(); expect_fwd("R5", 0, 0, 1);
        chk("R5", "reply_valid", int'(reply_valid), 0);
        req(0, 1, 5); step(); expect_fwd("R5", 0, 2, 1);
        chk("R9", "nack_valid", int'(nack_valid), 1);
        chk("R9", "nack_dst", int'(nack_dst), 1);
        chk("R9", "nack_line", int'(nack_line), 5);
        rsp(0, 0, 0); step();
        chk("R6", "early grant", int'(reply_valid), 0);
        chk("R5", "extra inval", int'(fwd_valid), 0);
        rsp(0, 2, 0); step(); expect_reply("R6", 1, 3, 1, 0);
    endtask

    task automatic t_nack_no_effect();                  // refused read of line 5 left no sharer
        req(1, 3, 5); step(); expect_reply("R9", 1, 3, 5, 0);
        chk("R9", "fwd_valid", int'(fwd_valid), 0);
    endtask

    task automatic t_read_modified();                   // line 1 owned by 3
        req(0, 0, 1); step(); expect_fwd("R6", 1, 3, 1); // only 3 is asked: sharers dropped
        chk("R7", "reply_valid", int'(reply_valid), 0);
        req(1, 2, 9); step();
        chk("R9", "nack_valid", int'(nack_valid), 1);
        chk("R9", "nack_dst", int'(nack_dst), 2);
        rsp(1, 3, 165); step(); expect_reply("R7", 0, 0, 1, 165);
        req(1, 1, 1); step(); expect_quiet("R7");       // sharers {0,3}
        step(); expect_fwd("R7", 0, 0, 1);
        step(); expect_fwd("R7", 0, 3, 1);
        rsp(0, 3, 0); step(); chk("R6", "early grant", int'(reply_valid), 0);
        rsp(0, 0, 0); step(); expect_reply("R7", 1, 1, 1, 165);
    endtask

    task automatic t_write_modified();                  // line 1 owned by 1
        req(1, 2, 1); step(); expect_fwd("R8", 2, 1, 1);
        rsp(1, 1, 60); step(); expect_reply("R8", 1, 2, 1, 60);
        req(0, 3, 1); step(); expect_fwd("R8", 1, 2, 1);
        rsp(1, 2, 119); step(); expect_reply("R8", 0, 3, 1, 119);
    endtask

    task automatic t_fast_grant();
        req(1, 2, 9); step(); expect_reply("R4", 1, 2, 9, 0);
        chk("R4", "fwd_valid", int'(fwd_valid), 0);
        req(0, 0, 13); step(); expect_reply("R3", 0, 0, 13, 0);
        req(1, 0, 13); step(); expect_reply("R4", 1, 0, 13, 0);
        chk("R4", "fwd_valid", int'(fwd_valid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_home_filter();
        t_read_shared();
        t_inval_round();
        t_nack_no_effect();
        t_read_modified();
        t_write_modified();
        t_fast_grant();
        step();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule